// File: doc/BRIEF.md
# Paced Complement-Pattern Packet Generator

This block is a synthesizable traffic source for one node of an m×n mesh network. It sends packets to the node at the mirrored position, (m-1-x, n-1-y). Each packet is a run of 34-bit flits. The two top bits of a flit mark where the packet starts and where it ends. The header carries the destination and a path for routing X first, then Y. The flit after the header carries the cycle in which the header left. Later flits carry a packet sequence number and the flit's position in the packet, so a receiver can work out latency and check integrity.

The offered load is a percentage. After each packet the generator stays idle for a number of cycles proportional to the packet length and to the share of time that is not used. An integer remainder is carried from one packet to the next, so no divider is needed and the average rate comes out exact. Flits leave under credit-based flow control. The node coordinates are static straps. Packet length and load are sampled when each packet starts.

Top module: `packet_traffic_gen`

## Requirements
- R1: Flit bit 33 is set only on the first flit of a packet, and bit 32 only on the last. A one-flit packet has both bits set. Every other flit has neither.
- R2: A packet has exactly `pkt_len` flits, for values 1 to 256 (0 acts as 1). The length is taken when the packet starts.
- R3: Header bits 31:28 hold the destination row MESH_Y-1-y, and bits 27:24 hold the destination column MESH_X-1-x.
- R4: Header bits 23:0 are a path of 3-bit hop codes, with the first hop in bits 2:0. All column hops come first (1 = +x, 2 = -x), then all row hops (3 = +y, 4 = -y). Every remaining hop is 0, which means eject.
- R5: The word of the second flit equals the number of cycles since reset was released, taken in the cycle the header left.
- R6: The flit at index i≥2 carries {seq[15:0], i[15:0]}. seq is 0 for the first packet after reset and grows by one per packet.
- R7: With load P in 1..100 and credit available, the generator inserts floor(D/P) idle cycles after each tail. D is L·(100-P) plus the remainder kept from the previous gap. The remainder D mod P is kept, and a new run starts with a remainder of 0. At P = 100 packets go back to back.
- R8: With load 0, no new packet starts. A packet already in progress is completed.
- R9: The credit count starts at CREDITS. It goes down by one per flit sent and up by one per `credit_in` pulse. `flit_valid` is high only while the count is non-zero, and a flit counts as sent in every cycle that `flit_valid` is high.
- R10: While stalled for credit, the flit on the output is held unchanged. Idle-cycle counting starts only after the tail has left.
- R11: During reset `flit_valid` is low. After reset the cycle count and the sequence number restart from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_x | input | XW | Column of this node |
| node_y | input | YW | Row of this node |
| pkt_len | input | 9 | Flits per packet, 1..256 |
| load_pct | input | 7 | Offered load in percent, 0..100 |
| credit_in | input | 1 | One returned credit per high cycle |
| flit_valid | output | 1 | A flit is sent this cycle |
| flit_data | output | 34 | {start, end, 32-bit word} |

## Verification
The bench builds the block for a 5×3 mesh, which is not square. A swap of rows and columns, or of the two hop groups, therefore shows up in every header. The self-mirrored centre node exercises an all-eject path, and an edge node exercises a path with no row hops. CREDITS is 4, so withholding credits stalls a 16-flit packet in its middle after exactly four flits. Single-flit packets at 33 % load make the carried remainder change the gap length from packet to packet. 256-flit packets reach the top of the length range.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

    localparam int WORD_W  = 32;
    localparam int FLIT_W  = WORD_W + 2;
    localparam int LEN_W   = 9;
    localparam int LOAD_W  = 7;
    localparam int DEBT_W  = 16;
    localparam int HOP_W   = 3;
    localparam int COORD_W = 4;
    localparam int PATH_W  = WORD_W - 2 * COORD_W;
    localparam int SEQ_W   = WORD_W / 2;
    localparam int IDX_W   = WORD_W - SEQ_W;
    localparam int FULL_LOAD = 100;

    typedef enum logic [1:0] {
        GEN_PARK = 2'd0,
        GEN_SEND = 2'd1,
        GEN_GAP  = 2'd2
    } gen_state_e;

    typedef enum logic [HOP_W-1:0] {
        HOP_EJECT = 3'd0,
        HOP_XPLUS = 3'd1,
        HOP_XMIN  = 3'd2,
        HOP_YPLUS = 3'd3,
        HOP_YMIN  = 3'd4
    } hop_e;

    typedef struct packed {
        logic              first;
        logic              last;
        logic [WORD_W-1:0] word;
    } flit_t;

    function automatic logic [LOAD_W-1:0] clamp_load(input logic [LOAD_W-1:0] p);
        return (p > LOAD_W'(FULL_LOAD)) ? LOAD_W'(FULL_LOAD) : p;
    endfunction

endpackage

// File: rtl/tgen_route.sv
module tgen_route
    import tgen_pkg::*;
#(
    parameter int MESH_X = 4,
    parameter int MESH_Y = 4,
    parameter int XW     = 2,
    parameter int YW     = 2
) (
    input  logic [XW-1:0]      src_x,
    input  logic [YW-1:0]      src_y,
    output logic [XW-1:0]      dst_x,
    output logic [YW-1:0]      dst_y,
    output logic [PATH_W-1:0]  path
);
    localparam int MAX_HOPS = (MESH_X - 1) + (MESH_Y - 1) + 1;
    localparam int USED_W   = MAX_HOPS * HOP_W;

    logic          go_xplus, go_yplus;
    logic [XW-1:0] x_dist;
    logic [YW-1:0] y_dist;
    logic [31:0]   x_hops, xy_hops;

    assign dst_x    = XW'(MESH_X - 1) - src_x;
    assign dst_y    = YW'(MESH_Y - 1) - src_y;
    assign go_xplus = dst_x > src_x;
    assign go_yplus = dst_y > src_y;
    assign x_dist   = go_xplus ? (dst_x - src_x) : (src_x - dst_x);
    assign y_dist   = go_yplus ? (dst_y - src_y) : (src_y - dst_y);
    assign x_hops   = 32'(x_dist);
    assign xy_hops  = 32'(x_dist) + 32'(y_dist);

    for (genvar h = 0; h < MAX_HOPS; h++) begin : g_hop
        hop_e code;
        always_comb begin
            if (32'(h) < x_hops)
                code = go_xplus ? HOP_XPLUS : HOP_XMIN;
            else if (32'(h) < xy_hops)
                code = go_yplus ? HOP_YPLUS : HOP_YMIN;
            else
                code = HOP_EJECT;
        end
        assign path[h*HOP_W +: HOP_W] = code;
    end

    if (USED_W < PATH_W) begin : g_pad
        assign path[PATH_W-1:USED_W] = '0;
    end

endmodule

// File: rtl/tgen_pacer.sv
module tgen_pacer
    import tgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LOAD_W-1:0] load_pct,
    input  logic [LEN_W-1:0]  cur_len,
    input  logic              tail_go,
    output logic              sending,
    output logic              launch
);
    gen_state_e        state_q, state_n;
    logic [DEBT_W-1:0] debt_q, debt_n;
    logic [LOAD_W-1:0] load_eff;
    logic [DEBT_W-1:0] load_w, added, grown, shrunk;

    assign load_eff = clamp_load(load_pct);
    assign load_w   = DEBT_W'(load_eff);
    assign added    = DEBT_W'(cur_len) * DEBT_W'(LOAD_W'(FULL_LOAD) - load_eff);
    assign grown    = debt_q + added;
    assign shrunk   = debt_q - load_w;

    always_comb begin
        state_n = state_q;
        debt_n  = debt_q;
        launch  = 1'b0;
        unique case (state_q)
            GEN_PARK: begin
                debt_n = '0;
                if (load_eff != '0) begin
                    state_n = GEN_SEND;
                    launch  = 1'b1;
                end
            end
            GEN_SEND: begin
                if (tail_go) begin
                    if (load_eff == '0) begin
                        state_n = GEN_PARK;
                        debt_n  = '0;
                    end else if (grown < load_w) begin
                        launch = 1'b1;
                        debt_n = grown;
                    end else begin
                        state_n = GEN_GAP;
                        debt_n  = grown;
                    end
                end
            end
            GEN_GAP: begin
                if (load_eff == '0) begin
                    state_n = GEN_PARK;
                    debt_n  = '0;
                end else begin
                    debt_n = shrunk;
                    if (shrunk < load_w) begin
                        state_n = GEN_SEND;
                        launch  = 1'b1;
                    end
                end
            end
            default: begin
                state_n = GEN_PARK;
                debt_n  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_PARK;
            debt_q  <= '0;
        end else begin
            state_q <= state_n;
            debt_q  <= debt_n;
        end
    end

    assign sending = (state_q == GEN_SEND);

endmodule

// File: rtl/tgen_credit.sv
module tgen_credit #(
    parameter int CREDITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic give_back,
    input  logic take,
    output logic has_credit
);
    localparam int CW = $clog2(CREDITS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CW'(CREDITS);
        else
            cnt_q <= cnt_q + CW'(give_back) - CW'(take);
    end

    assign has_credit = (cnt_q != '0);

endmodule

// File: rtl/packet_traffic_gen.sv
module packet_traffic_gen
    import tgen_pkg::*;
#(
    parameter int MESH_X  = 4,
    parameter int MESH_Y  = 4,
    parameter int CREDITS = 4,
    localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
    localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XW-1:0]     node_x,
    input  logic [YW-1:0]     node_y,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [LOAD_W-1:0] load_pct,
    input  logic              credit_in,
    output logic              flit_valid,
    output logic [FLIT_W-1:0] flit_data
);
    logic [XW-1:0]     dst_x;
    logic [YW-1:0]     dst_y;
    logic [PATH_W-1:0] path;
    logic              sending, launch, has_credit, stalled, tail_go, is_tail;
    logic [LEN_W-1:0]  len_q, idx_q;
    logic [WORD_W-1:0] cyc_q, ts_q;
    logic [SEQ_W-1:0]  seq_q;
    flit_t             cur;

    tgen_route #(.MESH_X(MESH_X), .MESH_Y(MESH_Y), .XW(XW), .YW(YW)) u_route (
        .src_x (node_x),
        .src_y (node_y),
        .dst_x (dst_x),
        .dst_y (dst_y),
        .path  (path)
    );

    tgen_pacer u_pacer (
        .clk      (clk),
        .rst      (rst),
        .load_pct (load_pct),
        .cur_len  (len_q),
        .tail_go  (tail_go),
        .sending  (sending),
        .launch   (launch)
    );

    tgen_credit #(.CREDITS(CREDITS)) u_credit (
        .clk        (clk),
        .rst        (rst),
        .give_back  (credit_in),
        .take       (flit_valid),
        .has_credit (has_credit)
    );

    assign flit_valid = sending && has_credit;
    assign stalled    = sending && !has_credit;
    assign is_tail    = (idx_q == len_q - LEN_W'(1));
    assign tail_go    = flit_valid && is_tail;

    always_comb begin
        cur.first = (idx_q == '0);
        cur.last  = is_tail;
        if (idx_q == '0)
            cur.word = {COORD_W'(dst_y), COORD_W'(dst_x), path};
        else if (idx_q == LEN_W'(1))
            cur.word = ts_q;
        else
            cur.word = {seq_q, IDX_W'(idx_q)};
    end

    assign flit_data = cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
            seq_q <= '0;
            ts_q  <= '0;
            len_q <= LEN_W'(1);
            idx_q <= '0;
        end else begin
            cyc_q <= cyc_q + WORD_W'(1);
            if (flit_valid && idx_q == '0)
                ts_q <= cyc_q;
            if (tail_go)
                seq_q <= seq_q + SEQ_W'(1);
            if (launch) begin
                len_q <= (pkt_len == '0) ? LEN_W'(1) : pkt_len;
                idx_q <= '0;
            end else if (flit_valid) begin
                idx_q <= idx_q + LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/tgen_checker.sv
module tgen_checker
    import tgen_pkg::*;
#(
    parameter int CREDITS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [LOAD_W-1:0] load_pct,
    input logic              credit_in,
    input logic              flit_valid,
    input logic [FLIT_W-1:0] flit_data,
    input logic [LEN_W-1:0]  len_q,
    input logic              stalled
);
    flit_t             f;
    logic              in_pkt;
    logic [LEN_W-1:0]  fcount;
    logic [7:0]        outs;
    logic [WORD_W-1:0] ccyc, hdr_cyc;

    assign f = flit_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt  <= 1'b0;
            fcount  <= '0;
            outs    <= '0;
            ccyc    <= '0;
            hdr_cyc <= '0;
        end else begin
            ccyc <= ccyc + WORD_W'(1);
            outs <= outs + 8'(flit_valid) - 8'(credit_in);
            if (flit_valid) begin
                if (f.first) hdr_cyc <= ccyc;
                if (f.last) begin
                    in_pkt <= 1'b0;
                    fcount <= '0;
                end else begin
                    in_pkt <= 1'b1;
                    fcount <= fcount + LEN_W'(1);
                end
            end
        end
    end

    assert_header_opens_R1: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && !in_pkt) |-> f.first);

    assert_no_inner_start_R1: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && in_pkt) |-> !f.first);

    assert_tail_count_R2: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && f.last) |-> (fcount + LEN_W'(1) == len_q));

    assert_stamp_word_R5: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && in_pkt && fcount == LEN_W'(1)) |-> (f.word == hdr_cyc));

    assert_full_load_R7: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && f.last && load_pct == LOAD_W'(FULL_LOAD)) |=> (flit_valid || stalled));

    assert_park_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (load_pct == '0 && $past(load_pct) == '0 && !in_pkt) |-> !flit_valid);

    assert_credit_bound_R9: assert property (@(posedge clk) disable iff (rst)
        flit_valid |-> (outs < 8'(CREDITS)));

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (stalled && $past(stalled)) |-> $stable(flit_data));

    assert_reset_quiet_R11: assert property (@(posedge clk)
        rst |=> !flit_valid);

endmodule

bind packet_traffic_gen tgen_checker #(.CREDITS(CREDITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_pct   (load_pct),
    .credit_in  (credit_in),
    .flit_valid (flit_valid),
    .flit_data  (flit_data),
    .len_q      (len_q),
    .stalled    (stalled)
);

// File: tb/packet_traffic_gen_test.sv
module packet_traffic_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int MX = 5;
    localparam int MY = 3;
    localparam int CR = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  node_x = '0;
    logic [1:0]  node_y = '0;
    logic [8:0]  pkt_len = 9'd1;
    logic [6:0]  load_req = '0;
    logic [6:0]  load_pct;
    logic        credit_in = 1'b0;
    logic        flit_valid;
    logic [33:0] flit_data;

    typedef struct {
        logic [33:0] flit;
        bit          ts;
        int          gap;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0, fails = 0;
    int   headers_seen = 0, stop_at = 0, flits_seen = 0;
    int   pend = 0, seq_m = 0, wd = 0;
    longint bcyc = 0, hdr_cyc = 0, last_cyc = 0;
    bit   hold = 1'b0;

    assign load_pct = (headers_seen >= stop_at) ? 7'd0 : load_req;

    packet_traffic_gen #(.MESH_X(MX), .MESH_Y(MY), .CREDITS(CR)) uut (
        .clk        (clk),
        .rst        (rst),
        .node_x     (node_x),
        .node_y     (node_y),
        .pkt_len    (pkt_len),
        .load_pct   (load_pct),
        .credit_in  (credit_in),
        .flit_valid (flit_valid),
        .flit_data  (flit_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (rst) bcyc <= 0;
        else     bcyc <= bcyc + 1;
        wd <= wd + 1;
        if (wd > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", wd);
            finish_run();
        end
    end

    // monitor: pops the scoreboard and returns credits
    always @(negedge clk) begin
        if (rst) begin
            pend = 0;
            credit_in = 1'b0;
        end else begin
            credit_in = 1'b0;
            if (flit_valid) begin
                flits_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected flit", longint'(flit_data), 0);
                end else begin
                    exp_t it;
                    logic [33:0] want;
                    it = exp_q.pop_front();
                    want = it.flit;
                    if (it.ts) want[31:0] = hdr_cyc[31:0];
                    check(flit_data == want, it.req, "flit", longint'(flit_data), longint'(want));
                    if (it.gap >= 0)
                        check(bcyc - last_cyc == it.gap, "R7", "cycles between flits",
                              bcyc - last_cyc, it.gap);
                end
                last_cyc = bcyc;
                if (flit_data[33]) begin
                    hdr_cyc = bcyc;
                    headers_seen++;
                end
                pend++;
            end
            if (pend > 0 && !hold) begin
                credit_in = 1'b1;
                pend--;
            end
        end
    end

    function automatic logic [23:0] xy_path(input int sx, input int sy, input int dx, input int dy);
        logic [23:0] p = '0;
        int h = 0;
        for (int k = 0; k < ((dx > sx) ? dx - sx : sx - dx); k++) begin
            p[h*3 +: 3] = (dx > sx) ? 3'd1 : 3'd2;
            h++;
        end
        for (int k = 0; k < ((dy > sy) ? dy - sy : sy - dy); k++) begin
            p[h*3 +: 3] = (dy > sy) ? 3'd3 : 3'd4;
            h++;
        end
        return p;
    endfunction

    // driver: pushes the expected flits of n packets, then launches them
    task automatic run_case(input int nx, input int ny, input int len, input int load,
                            input int n, input bit gaps_on);
        int dx = MX - 1 - nx;
        int dy = MY - 1 - ny;
        int debt = 0;
        exp_t it;
        @(negedge clk);
        node_x = 3'(nx);
        node_y = 2'(ny);
        for (int p = 0; p < n; p++) begin
            it.ts = 1'b0;
            it.req = "R1,R3,R4 header";
            it.flit = {1'b1, len == 1, 4'(dy), 4'(dx), xy_path(nx, ny, dx, dy)};
            if (p == 0 || !gaps_on) it.gap = -1;
            else begin
                debt += len * (100 - load);
                it.gap = 1 + debt / load;
                debt = debt % load;
            end
            exp_q.push_back(it);
            if (len >= 2) begin
                it.ts = 1'b1;
                it.req = "R5 stamp";
                it.flit = {1'b0, len == 2, 32'd0};
                it.gap = gaps_on ? 1 : -1;
                exp_q.push_back(it);
            end
            for (int i = 2; i < len; i++) begin
                it.ts = 1'b0;
                it.req = (i == len - 1) ? "R2,R6 tail" : "R6 body";
                it.flit = {1'b0, i == len - 1, 16'(seq_m), 16'(i)};
                it.gap = gaps_on ? 1 : -1;
                exp_q.push_back(it);
            end
            seq_m++;
        end
        pkt_len = 9'(len);
        load_req = 7'(load);
        stop_at = headers_seen + n;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(flit_valid == 1'b0, "R8", "quiet after last packet", flit_valid, 0);
    endtask

    initial begin
        int h0, base;
        repeat (3) begin
            @(negedge clk);
            check(flit_valid == 1'b0, "R11", "valid during reset", flit_valid, 0);
        end
        rst = 1'b0;

        // R3 R4: row stays, columns cross; R5 R6 R7 at half load
        run_case(0, 1, 4, 50, 4, 1'b1);
        // R1 single flit, R7 remainder carried at 33 percent
        run_case(4, 2, 1, 33, 40, 1'b1);
        // R4 all-eject path, R7 back to back at full load
        run_case(2, 1, 2, 100, 5, 1'b1);

        // R8: load 0 starts nothing
        @(negedge clk);
        pkt_len = 9'd5;
        load_req = 7'd60;
        stop_at = headers_seen;
        base = flits_seen;
        repeat (40) @(negedge clk);
        check(flits_seen == base, "R8", "flits at zero load", flits_seen - base, 0);

        // R2 longest packets
        run_case(1, 0, 256, 90, 2, 1'b1);

        // R9 R10: withhold credits in the middle of a packet
        h0 = headers_seen;
        fork
            run_case(3, 2, 16, 100, 2, 1'b0);
            begin
                while (headers_seen == h0) @(posedge clk);
                @(posedge clk);
                hold = 1'b1;
                base = flits_seen;
                repeat (20) @(posedge clk);
                @(negedge clk);
                check(flits_seen - base == CR, "R9", "flits sent while credits held",
                      flits_seen - base, CR);
                check(flit_valid == 1'b0, "R10", "valid while stalled", flit_valid, 0);
                @(posedge clk);
                hold = 1'b0;
            end
        join

        // R11: reset restarts cycle count and sequence
        @(negedge clk);
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(flit_valid == 1'b0, "R11", "valid during reset", flit_valid, 0);
        end
        rst = 1'b0;
        seq_m = 0;
        run_case(0, 0, 3, 25, 3, 1'b1);

        finish_run();
    end

endmodule